// File: doc/BRIEF.md
# Streaming Stall Watchdog with Recovery Cap

This block watches a streaming data pipeline and recovers it when it wedges. While a streaming session is open it samples a free-running transfer progress count once per poll interval. When the count has not moved for three polls in a row, and the capture engine reports one of its stall states at that poll, the pipeline is declared wedged. The watchdog then asks the rest of the system to stop the engine and waits for the stop to be confirmed. Once the sample clock is enabled and its PLL is locked, it issues a one-cycle re-arm request and resumes watching.

A session opens on a start command and closes on a stop command. Both commands clear the count of consecutive recoveries. A runtime cap limits how many recoveries one session may make; a cap of zero removes the limit. When a wedge is found after the cap has been used up, the watchdog gives up. It raises a capped flag and stays passive until the next start command.

Top module: `stall_watchdog`

## Requirements
- R1: During and after reset, `stop_req`, `rearm_req` and `capped` are low and no session is open.
- R2: With a session open, `stop_req` rises on the third consecutive poll (poll period `POLL_CLKS` clocks, counted from the start command) at which `progress_cnt` equals the value seen at the previous poll. It therefore becomes visible 3 x `POLL_CLKS` clocks after the edge that accepts `start_cmd`.
- R3: A change in `progress_cnt` seen at any poll restarts the run of unchanged polls, so three further unchanged polls are needed.
- R4: A wedge is declared only when `engine_state` (4-bit code) is 5, 7, 8 or 9 at the deciding poll. Any other code never raises `stop_req`.
- R5: Once raised, `stop_req` stays high until the clock edge that samples `stop_done` high, unless a start or stop command arrives first.
- R6: At the edge that accepts `stop_done`, `rearm_req` pulses for exactly one cycle if `clk_enabled` and `pll_locked` are both high. Otherwise no pulse is given until the first edge at which both are high, and that edge gives the pulse.
- R7: With `recov_cap` = N > 0, after N recoveries in one session the next wedge sets `capped` and does not raise `stop_req`. With `recov_cap` = 0, recoveries never stop.
- R8: `capped` stays high through anything but a start command, a stop command included, and falls at the edge that accepts `start_cmd`.
- R9: A start command clears the recovery count, so a new session again allows `recov_cap` recoveries. A stop command also clears it.
- R10: With no session open (before a start, or after a stop command) `stop_req` stays low whatever the progress and engine inputs. A stop command during a pending stop drops `stop_req` at once.
- R11: After a re-arm, watching restarts from a fresh baseline. The next `stop_req` needs three more unchanged polls, 3 x `POLL_CLKS` clocks after the re-arm edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| progress_cnt | input | CNT_W | Transfer progress count from the pipeline |
| engine_state | input | 4 | Current state code of the capture engine |
| clk_enabled | input | 1 | Sample clock output is enabled |
| pll_locked | input | 1 | Sample clock PLL is locked |
| stop_done | input | 1 | Requested stop has completed |
| start_cmd | input | 1 | Open a session (one-cycle pulse) |
| stop_cmd | input | 1 | Close the session (one-cycle pulse) |
| recov_cap | input | CAP_W | Consecutive recovery limit, 0 for unlimited |
| stop_req | output | 1 | Request to stop the capture engine |
| rearm_req | output | 1 | One-cycle request to re-arm the pipeline |
| capped | output | 1 | Recovery cap exhausted, waiting for a start |

## Verification
A wrong poll counter or stall count shows up as `stop_req` rising one poll period early or late. It can be seen within three poll periods of a start or a re-arm, so every check samples the exact poll at which the stop must appear and the one before it. A leaked recovery count shows up as `capped` rising in place of a stop on the first wedge after a start. A lost clock-health gate shows up as a `rearm_req` pulse in the cycle after `stop_done` while the clock is reported down. A controller stuck in its stop phase is caught by the check that `stop_req` stays high until `stop_done` and falls the cycle after.

// File: rtl/sw_pkg.sv
package sw_pkg;

  localparam int ENG_W = 4;

  typedef enum logic [2:0] {
    WD_IDLE,
    WD_WATCH,
    WD_STOP,
    WD_CLKWAIT,
    WD_CAPPED
  } wd_state_t;

  // Engine codes that count as stalled (busy or waiting on a buffer).
  function automatic logic in_stall_state(input logic [ENG_W-1:0] code);
    return (code == 4'd5) || (code == 4'd7) || (code == 4'd8) || (code == 4'd9);
  endfunction

  // True when no further recovery is allowed; cap 0 means unlimited.
  function automatic logic cap_reached(input int unsigned done_cnt, input int unsigned cap);
    return (cap != 0) && (done_cnt >= cap);
  endfunction

endpackage

// File: rtl/sw_poll_timer.sv
module sw_poll_timer #(
  parameter int POLL_CLKS = 6_400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = (POLL_CLKS > 2) ? $clog2(POLL_CLKS) : 1;

  logic [TW-1:0] cnt;

  assign tick = run && (cnt == TW'(POLL_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sw_stall_detect.sv
module sw_stall_detect
  import sw_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int STALL_POLLS = 3,
  localparam int SW         = $clog2(STALL_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] progress,
  input  logic [ENG_W-1:0] engine_state,
  output logic             wedge,
  output logic [SW-1:0]    stall_polls
);
  logic [CNT_W-1:0] base;
  logic             same;

  assign same  = (progress == base);
  assign wedge = run && tick && same &&
                 (stall_polls >= SW'(STALL_POLLS - 1)) &&
                 in_stall_state(engine_state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base        <= '0;
      stall_polls <= '0;
    end else if (!run) begin
      base        <= progress;
      stall_polls <= '0;
    end else if (tick) begin
      if (!same) begin
        base        <= progress;
        stall_polls <= '0;
      end else if (stall_polls < SW'(STALL_POLLS)) begin
        stall_polls <= stall_polls + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sw_recov_ctrl.sv
module sw_recov_ctrl
  import sw_pkg::*;
#(
  parameter int CAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic             wedge,
  input  logic             stop_done,
  input  logic             clk_ok,
  input  logic [CAP_W-1:0] recov_cap,
  output logic             run,
  output logic             stop_req,
  output logic             rearm_req,
  output logic             capped
);
  wd_state_t        state;
  logic [CAP_W-1:0] n_rec;
  logic             rearm_q;

  assign run       = (state == WD_WATCH);
  assign stop_req  = (state == WD_STOP);
  assign capped    = (state == WD_CAPPED);
  assign rearm_req = rearm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= WD_IDLE;
      n_rec   <= '0;
      rearm_q <= 1'b0;
    end else begin
      rearm_q <= 1'b0;
      if (stop_cmd) begin
        n_rec <= '0;
        if (state != WD_CAPPED) state <= WD_IDLE;
      end else if (start_cmd) begin
        n_rec <= '0;
        state <= WD_WATCH;
      end else begin
        case (state)
          WD_WATCH: if (wedge) begin
            if (cap_reached(32'(n_rec), 32'(recov_cap))) begin
              state <= WD_CAPPED;
            end else begin
              state <= WD_STOP;
              if (n_rec != '1) n_rec <= n_rec + 1'b1;
            end
          end
          WD_STOP: if (stop_done) begin
            if (clk_ok) begin
              state   <= WD_WATCH;
              rearm_q <= 1'b1;
            end else begin
              state <= WD_CLKWAIT;
            end
          end
          WD_CLKWAIT: if (clk_ok) begin
            state   <= WD_WATCH;
            rearm_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/stall_watchdog.sv
module stall_watchdog
  import sw_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int POLL_CLKS   = 6_400_000,
  parameter int STALL_POLLS = 3,
  parameter int CAP_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] progress_cnt,
  input  logic [3:0]       engine_state,
  input  logic             clk_enabled,
  input  logic             pll_locked,
  input  logic             stop_done,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic [CAP_W-1:0] recov_cap,
  output logic             stop_req,
  output logic             rearm_req,
  output logic             capped
);
  localparam int SW = $clog2(STALL_POLLS + 1);

  logic          run_w;
  logic          tick_w;
  logic          wedge_w;
  logic [SW-1:0] stall_polls_w;
  logic          clk_ok_w;

  assign clk_ok_w = clk_enabled && pll_locked;

  sw_poll_timer #(.POLL_CLKS(POLL_CLKS)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_w),
    .tick (tick_w)
  );

  sw_stall_detect #(.CNT_W(CNT_W), .STALL_POLLS(STALL_POLLS)) u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_w),
    .tick        (tick_w),
    .progress    (progress_cnt),
    .engine_state(engine_state),
    .wedge       (wedge_w),
    .stall_polls (stall_polls_w)
  );

  sw_recov_ctrl #(.CAP_W(CAP_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_cmd(start_cmd),
    .stop_cmd (stop_cmd),
    .wedge    (wedge_w),
    .stop_done(stop_done),
    .clk_ok   (clk_ok_w),
    .recov_cap(recov_cap),
    .run      (run_w),
    .stop_req (stop_req),
    .rearm_req(rearm_req),
    .capped   (capped)
  );
endmodule

// File: rtl/sw_wdg_checker.sv
module sw_wdg_checker
  import sw_pkg::*;
#(
  parameter int STALL_POLLS = 3,
  localparam int SW         = $clog2(STALL_POLLS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    engine_state,
  input logic          clk_enabled,
  input logic          pll_locked,
  input logic          stop_done,
  input logic          start_cmd,
  input logic          stop_cmd,
  input logic          stop_req,
  input logic          rearm_req,
  input logic          capped,
  input logic [SW-1:0] stall_polls
);
  AST_STOP_AFTER_STALL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> ($past(stall_polls) >= SW'(STALL_POLLS - 1))); // R2

  AST_STOP_ONLY_IN_STALL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> $past(in_stall_state(engine_state))); // R4

  AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !stop_done && !start_cmd && !stop_cmd) |=> stop_req); // R5

  AST_REARM_CLOCK_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_req |-> $past(clk_enabled && pll_locked)); // R6

  AST_REARM_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_req |=> !rearm_req); // R6

  AST_CAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    capped |-> (!stop_req && !rearm_req)); // R7

  AST_CAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (capped && !start_cmd) |=> capped); // R8
endmodule

bind stall_watchdog sw_wdg_checker #(.STALL_POLLS(STALL_POLLS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .engine_state(engine_state),
  .clk_enabled (clk_enabled),
  .pll_locked  (pll_locked),
  .stop_done   (stop_done),
  .start_cmd   (start_cmd),
  .stop_cmd    (stop_cmd),
  .stop_req    (stop_req),
  .rearm_req   (rearm_req),
  .capped      (capped),
  .stall_polls (stall_polls_w)
);

// File: tb/test_stall_watchdog.sv
`timescale 1ns/1ps
module test_stall_watchdog;
  localparam int P     = 8;
  localparam int CW    = 32;
  localparam int CAPW  = 8;
  localparam int WEDGE = 3 * P;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [CW-1:0]   progress_cnt;
  logic [3:0]      engine_state;
  logic            clk_enabled, pll_locked, stop_done, start_cmd, stop_cmd;
  logic [CAPW-1:0] recov_cap;
  logic            stop_req, rearm_req, capped;

  int n_chk = 0;
  int n_fail = 0;
  bit moving = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stall_watchdog #(.CNT_W(CW), .POLL_CLKS(P), .STALL_POLLS(3), .CAP_W(CAPW)) i_stall_watchdog (
    .clk(clk), .rst_n(rst_n), .progress_cnt(progress_cnt), .engine_state(engine_state),
    .clk_enabled(clk_enabled), .pll_locked(pll_locked), .stop_done(stop_done),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd), .recov_cap(recov_cap),
    .stop_req(stop_req), .rearm_req(rearm_req), .capped(capped)
  );

  // Scenario vectors: [7:4] engine code, [3] progress moving, [2] clock healthy, [1] stop expected
  localparam logic [7:0] VEC [8] = '{
    {4'd5, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd7, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd8, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd9, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd2, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd1, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd5, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'd0, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      if (moving) progress_cnt = progress_cnt + 1;
    end
  endtask

  task automatic do_start();
    start_cmd = 1'b1; cyc(1); start_cmd = 1'b0;
  endtask

  task automatic do_stop();
    stop_cmd = 1'b1; cyc(1); stop_cmd = 1'b0;
  endtask

  task automatic set_clk(input logic ok);
    clk_enabled = ok; pll_locked = ok;
  endtask

  // Confirms the pending stop; leaves the bench one half cycle after the confirming edge.
  task automatic confirm_stop(input logic exp_rearm, input string req);
    stop_done = 1'b1; cyc(1); stop_done = 1'b0;
    chk(stop_req, 1'b0, "R5");
    chk(rearm_req, exp_rearm, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; progress_cnt = '0; engine_state = 4'd0; set_clk(1'b1);
    stop_done = 1'b0; start_cmd = 1'b0; stop_cmd = 1'b0; recov_cap = '0;
    cyc(3);
    chk(stop_req, 1'b0, "R1");
    chk(rearm_req, 1'b0, "R1");
    chk(capped, 1'b0, "R1");
    rst_n = 1'b1;
    cyc(2);

    // R10: stalled inputs with no session open
    engine_state = 4'd5;
    cyc(5 * P);
    chk(stop_req, 1'b0, "R10");

    // Vector walk: R2 timing, R4 state gate, R5 hold, R6 clock gate
    for (int i = 0; i < 8; i++) begin
      do_stop();
      engine_state = VEC[i][7:4];
      moving       = VEC[i][3];
      set_clk(VEC[i][2]);
      do_start();
      cyc(WEDGE - 1);
      chk(stop_req, 1'b0, "R2");
      cyc(1);
      chk(stop_req, VEC[i][1], VEC[i][1] ? "R2" : "R4");
      if (VEC[i][1]) begin
        cyc(3);
        chk(stop_req, 1'b1, "R5");
        confirm_stop(VEC[i][2], "R6");
        cyc(1);
        chk(rearm_req, 1'b0, "R6");
        if (!VEC[i][2]) begin
          cyc(3);
          chk(rearm_req, 1'b0, "R6");
          set_clk(1'b1);
          cyc(1);
          chk(rearm_req, 1'b1, "R6");
          cyc(1);
          chk(rearm_req, 1'b0, "R6");
        end
      end else begin
        cyc(2 * P);
        chk(stop_req, 1'b0, "R4");
      end
      moving = 1'b0;
    end

    // R3: one progress change between polls restarts the run
    do_stop(); engine_state = 4'd5; set_clk(1'b1);
    do_start();
    cyc(12);
    progress_cnt = progress_cnt + 1;
    cyc(11);
    chk(stop_req, 1'b0, "R3");
    cyc(16);
    chk(stop_req, 1'b0, "R3");
    cyc(1);
    chk(stop_req, 1'b1, "R3");
    confirm_stop(1'b1, "R6");

    // R11: fresh baseline after re-arm
    cyc(WEDGE - 1);
    chk(stop_req, 1'b0, "R11");
    cyc(1);
    chk(stop_req, 1'b1, "R11");
    confirm_stop(1'b1, "R6");

    // R7: cap of 2
    do_stop(); recov_cap = 8'd2;
    do_start();
    for (int r = 0; r < 2; r++) begin
      cyc(WEDGE);
      chk(stop_req, 1'b1, "R7");
      confirm_stop(1'b1, "R7");
    end
    cyc(WEDGE - 1);
    chk(capped, 1'b0, "R7");
    cyc(1);
    chk(capped, 1'b1, "R7");
    chk(stop_req, 1'b0, "R7");
    cyc(2 * P);
    chk(stop_req, 1'b0, "R7");
    chk(rearm_req, 1'b0, "R7");

    // R8: capped survives a stop, falls on a start
    do_stop();
    chk(capped, 1'b1, "R8");
    cyc(P);
    chk(capped, 1'b1, "R8");
    do_start();
    chk(capped, 1'b0, "R8");

    // R9: start cleared the count, recovery allowed again
    cyc(WEDGE);
    chk(stop_req, 1'b1, "R9");
    chk(capped, 1'b0, "R9");
    confirm_stop(1'b1, "R9");

    // R7: cap 0 never caps
    do_stop(); recov_cap = 8'd0;
    do_start();
    for (int r = 0; r < 4; r++) begin
      cyc(WEDGE);
      chk(stop_req, 1'b1, "R7");
      confirm_stop(1'b1, "R7");
    end
    chk(capped, 1'b0, "R7");

    // R10: stop command while a stop is pending, then stays quiet
    cyc(WEDGE);
    chk(stop_req, 1'b1, "R2");
    do_stop();
    chk(stop_req, 1'b0, "R10");
    cyc(5 * P);
    chk(stop_req, 1'b0, "R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule